// File: doc/BRIEF.md
# Two-Bank Flash Command Front End with Key Lock

This block is the register side of an embedded flash controller that has two banks. A simple bus writes and reads a small register file. Each bank has a key register, a control register and a status register. Behind the register file sits a model of the memory array. A bank leaves reset locked. Its control register accepts changes only after two fixed key words arrive in order at that bank's key register.

While its program-enable bit is set, an unlocked bank collects eight 32-bit array writes in a write buffer. It then commits them together as one 256-bit flash word. Setting the start bit together with the sector-erase bit fills every word of the selected sector with ones. Each operation waits a parameterised number of cycles and then writes the array one word per cycle. At the end it raises end-of-operation. An operation that arrives at the wrong moment is dropped and raises a sticky sequence-error flag.

Top module: `flash_keylock_ctrl`

## Requirements
- R1: After reset, each bank's control register reads 0x00000001 (bit 0 = locked) and its status register reads 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to a bank's key register clears bit 0 of that bank's control register. The other bank stays locked.
- R3: A key write with any other value, or any key write while the bank is unlocked, locks the bank for good. A correct key pair no longer unlocks it until the next reset.
- R4: Control fields are program-enable at bit 0x2, sector-erase at bit 0x4, bulk at bit 0x8, size at bit 0x10, start at bit 0x80 (reads 0) and sector number at bits 10:8. A control write while locked changes no field. Writing 1 to bit 0 while unlocked locks the bank again.
- R5: With program-enable set, eight array writes fill the buffer. Bit 1 of status is set while the buffer is partly filled. Bit 2 is set from the first accepted write until the commit ends. The flash word goes to bank addr[20], sector addr[19:17], flash word addr[5], with the 32-bit lane taken from addr[4:2]. All other words keep their contents, and an unwritten array reads all ones.
- R6: A status read whose sampling cycle is k cycles after the accepting cycle shows busy (bit 0) together with bit 2 for 1 ≤ k ≤ LAT+8 after a program, or LAT+16 after an erase. At the next cycle busy and bit 2 are clear and end-of-operation (bit 16) is set.
- R7: A control write with start and sector-erase set, on an unlocked idle bank, sets all sixteen modelled words of the selected sector to 0xFFFFFFFF and leaves other sectors unchanged.
- R8: An array write while locked, busy or without program-enable, or a start while locked, busy or without sector-erase, is discarded and sets bit 18 of status. Writing 1 to bit 16 or bit 18 of status clears that flag.
- R9: Register space (bus_reg=1) decodes addr[7:0] as key 0x04, control 0x0C and status 0x10, and addr[8] selects the bank. Reads of the key register and of unmapped offsets return 0.
- R10: bus_rdata carries the requested value in the cycle after bus_re is sampled, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_reg | input | 1 | 1 = register space, 0 = flash array |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |

## Verification
The hardest state to reach from the ports is a bank that is busy with one operation while a second start or a buffered write arrives. That collision must drop the second request and set the sequence error without disturbing the running commit or erase. The stimulus gets there by issuing an erase and then another start on the very next cycle. Status reads are placed exactly at the last busy cycle and the first idle cycle, so an off-by-one in the latency counter or the word walk shows up. A reference model in the bench, built from integer counters and plain arrays, predicts bus_rdata on every clock.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [31:0] KEY_A = 32'h45670123;
  localparam logic [31:0] KEY_B = 32'hCDEF89AB;

  localparam int CR_LOCK   = 0;
  localparam int CR_PG     = 1;
  localparam int CR_SER    = 2;
  localparam int CR_BER    = 3;
  localparam int CR_PSIZE  = 4;
  localparam int CR_STRT   = 7;
  localparam int CR_SNB_LO = 8;

  localparam int SR_BSY  = 0;
  localparam int SR_WBNE = 1;
  localparam int SR_QW   = 2;
  localparam int SR_EOP  = 16;
  localparam int SR_PGS  = 18;

  localparam logic [7:0] OFF_KEY = 8'h04;
  localparam logic [7:0] OFF_CR  = 8'h0C;
  localparam logic [7:0] OFF_SR  = 8'h10;

  localparam int NBANK = 2;

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN, LK_DEAD} lk_t;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_WRITE} ph_t;
endpackage

// File: rtl/fc_keylock.sv
module fc_keylock
  import fc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        open_o
);
  lk_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LK_SHUT;
    end else if (key_we) begin
      case (st)
        LK_SHUT: st <= (key_data == KEY_A) ? LK_HALF : LK_DEAD;
        LK_HALF: st <= (key_data == KEY_B) ? LK_OPEN : LK_DEAD;
        default: st <= LK_DEAD;
      endcase
    end else if (relock && st == LK_OPEN) begin
      st <= LK_SHUT;
    end
  end

  assign open_o = (st == LK_OPEN);

  p_open_needs_second_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(key_we && key_data == KEY_B));

  p_dead_is_final_r3: assert property (@(posedge clk) disable iff (rst)
    (st == LK_DEAD) |=> (st == LK_DEAD) && !open_o);
endmodule

// File: rtl/fc_bank.sv
module fc_bank
  import fc_pkg::*;
#(
  parameter int LAT       = 4,
  parameter int SECT_BITS = 3,
  parameter int FW_BITS   = 1,
  parameter int LANES     = 8,
  parameter int BANK_AW   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_we,
  input  logic               cr_we,
  input  logic               sr_we,
  input  logic               arr_we,
  input  logic               arr_re,
  input  logic [31:0]        wdata,
  input  logic [BANK_AW-1:0] arr_addr,
  output logic [31:0]        cr_o,
  output logic [31:0]        sr_o,
  output logic [31:0]        arr_rdata
);
  localparam int LANE_BITS = $clog2(LANES);
  localparam int WIDX_W    = FW_BITS + LANE_BITS;
  localparam int IDX_W     = SECT_BITS + WIDX_W;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int FILL_W    = LANE_BITS + 1;
  localparam int CNT_W     = $clog2(LAT + 1);
  localparam int TGT_W     = SECT_BITS + FW_BITS;
  localparam int MID_LO    = 2 + WIDX_W;
  localparam int MID_HI    = BANK_AW - SECT_BITS - 1;
  localparam logic [WIDX_W-1:0] PROG_LAST  = WIDX_W'(LANES - 1);
  localparam logic [WIDX_W-1:0] ERASE_LAST = '1;

  logic open;
  logic pg, ser, ber, psz, eop, pgs, is_erase;
  logic [SECT_BITS-1:0] snb, esect;
  logic [FILL_W-1:0]    fill;
  logic [TGT_W-1:0]     tgt;
  logic [CNT_W-1:0]     cnt;
  logic [WIDX_W-1:0]    widx;
  logic [31:0]          wbuf [LANES];
  logic [31:0]          mem  [DEPTH];
  ph_t                  phase;

  logic [LANE_BITS-1:0] lane;
  logic [TGT_W-1:0]     a_tgt;
  logic [IDX_W-1:0]     ridx, mem_idx;
  logic [31:0]          mem_d;
  logic busy, qw, strt, start_erase, strt_bad, wr_ok, wr_bad, last_wr, done, mem_we;
  logic unused_addr;

  fc_keylock u_lock (
    .clk(clk), .rst(rst), .key_we(key_we), .key_data(wdata),
    .relock(cr_we && wdata[CR_LOCK]), .open_o(open)
  );

  assign lane        = arr_addr[2 +: LANE_BITS];
  assign a_tgt       = {arr_addr[BANK_AW-1 -: SECT_BITS], arr_addr[2+LANE_BITS +: FW_BITS]};
  assign ridx        = {a_tgt, lane};
  assign unused_addr = ^{arr_addr[1:0], arr_addr[MID_HI:MID_LO]};

  assign busy        = (phase != PH_IDLE);
  assign qw          = busy || (fill != '0);
  assign strt        = cr_we && wdata[CR_STRT];
  assign start_erase = strt && open && !qw && wdata[CR_SER];
  assign strt_bad    = strt && !start_erase;
  assign wr_ok       = arr_we && open && pg && !busy;
  assign wr_bad      = arr_we && !wr_ok;
  assign last_wr     = wr_ok && (fill == FILL_W'(LANES - 1));
  assign done        = (phase == PH_WRITE) && (widx == (is_erase ? ERASE_LAST : PROG_LAST));

  // control fields and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      {pg, ser, ber, psz} <= '0;
      snb <= '0;
      eop <= 1'b0;
      pgs <= 1'b0;
    end else begin
      if (cr_we && open) begin
        pg  <= wdata[CR_PG];
        ser <= wdata[CR_SER];
        ber <= wdata[CR_BER];
        psz <= wdata[CR_PSIZE];
        snb <= wdata[CR_SNB_LO +: SECT_BITS];
      end
      if (strt_bad || wr_bad)          pgs <= 1'b1;
      else if (sr_we && wdata[SR_PGS]) pgs <= 1'b0;
      if (done)                        eop <= 1'b1;
      else if (sr_we && wdata[SR_EOP]) eop <= 1'b0;
    end
  end

  // operation sequencer: latency wait, then one array word per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      fill     <= '0;
      cnt      <= '0;
      widx     <= '0;
      tgt      <= '0;
      esect    <= '0;
      is_erase <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (wr_ok && fill == '0) tgt <= a_tgt;
          if (last_wr) begin
            phase    <= PH_WAIT;
            cnt      <= CNT_W'(LAT - 1);
            is_erase <= 1'b0;
            fill     <= '0;
          end else if (wr_ok) begin
            fill <= fill + 1'b1;
          end else if (start_erase) begin
            phase    <= PH_WAIT;
            cnt      <= CNT_W'(LAT - 1);
            is_erase <= 1'b1;
            esect    <= wdata[CR_SNB_LO +: SECT_BITS];
          end
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            phase <= PH_WRITE;
            widx  <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          widx <= widx + 1'b1;
          if (done) phase <= PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_ok) begin
        if (lane == LANE_BITS'(i))  wbuf[i] <= wdata;
        else if (fill == '0)        wbuf[i] <= '1;
      end
    end
  end

  assign mem_we  = (phase == PH_WRITE);
  assign mem_idx = is_erase ? {esect, widx} : {tgt, widx[LANE_BITS-1:0]};
  assign mem_d   = is_erase ? '1 : wbuf[widx[LANE_BITS-1:0]];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_idx] <= mem_d;
    if (arr_re) arr_rdata <= mem[ridx];
  end

  always_comb begin
    cr_o = '0;
    cr_o[CR_LOCK]  = !open;
    cr_o[CR_PG]    = pg;
    cr_o[CR_SER]   = ser;
    cr_o[CR_BER]   = ber;
    cr_o[CR_PSIZE] = psz;
    cr_o[CR_SNB_LO +: SECT_BITS] = snb;
    sr_o = '0;
    sr_o[SR_BSY]  = busy;
    sr_o[SR_WBNE] = (fill != '0) && !busy;
    sr_o[SR_QW]   = qw;
    sr_o[SR_EOP]  = eop;
    sr_o[SR_PGS]  = pgs;
  end

  p_locked_cr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (cr_we && !open) |=> $stable(cr_o[CR_SNB_LO+SECT_BITS-1:1]));

  p_wbne_only_idle_r5: assert property (@(posedge clk) disable iff (rst)
    sr_o[SR_WBNE] |-> !sr_o[SR_BSY] && sr_o[SR_QW]);

  p_qw_covers_busy_r6: assert property (@(posedge clk) disable iff (rst)
    sr_o[SR_BSY] |-> sr_o[SR_QW]);

  p_eop_with_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_o[SR_BSY]) |-> sr_o[SR_EOP]);

  p_locked_write_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (arr_we && !open) |=> sr_o[SR_PGS]);
endmodule

// File: rtl/flash_keylock_ctrl.sv
module flash_keylock_ctrl
  import fc_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int LAT       = 4,
  parameter int SECT_BITS = 3,
  parameter int FW_BITS   = 1,
  parameter int LANES     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_reg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int BANK_AW = ADDR_W - 1;

  logic [31:0] cr_w  [NBANK];
  logic [31:0] sr_w  [NBANK];
  logic [31:0] ard_w [NBANK];
  logic [7:0]  off;
  logic        rbank, abank;
  logic [31:0] reg_q;
  logic        sel_arr_q, abank_q;

  assign off   = bus_addr[7:0];
  assign rbank = bus_addr[8];
  assign abank = bus_addr[ADDR_W-1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_r, hit_a;
    assign hit_r = bus_reg && (rbank == 1'(b));
    assign hit_a = !bus_reg && (abank == 1'(b));

    fc_bank #(
      .LAT(LAT), .SECT_BITS(SECT_BITS), .FW_BITS(FW_BITS),
      .LANES(LANES), .BANK_AW(BANK_AW)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .key_we   (bus_we && hit_r && off == OFF_KEY),
      .cr_we    (bus_we && hit_r && off == OFF_CR),
      .sr_we    (bus_we && hit_r && off == OFF_SR),
      .arr_we   (bus_we && hit_a),
      .arr_re   (bus_re && hit_a),
      .wdata    (bus_wdata),
      .arr_addr (bus_addr[BANK_AW-1:0]),
      .cr_o     (cr_w[b]),
      .sr_o     (sr_w[b]),
      .arr_rdata(ard_w[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_arr_q <= 1'b0;
      abank_q   <= 1'b0;
    end else if (bus_re) begin
      sel_arr_q <= !bus_reg;
      abank_q   <= abank;
      if (bus_reg) begin
        case (off)
          OFF_CR:  reg_q <= cr_w[rbank];
          OFF_SR:  reg_q <= sr_w[rbank];
          default: reg_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = sel_arr_q ? ard_w[abank_q] : reg_q;
endmodule

// File: tb/flash_keylock_ctrl_test.sv
module flash_keylock_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_reg = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int    checks = 0, bad = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R1";

  flash_keylock_ctrl uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_reg(bus_reg),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          lk [2];      // 0 shut, 1 half, 2 open, 3 dead
  bit          mpg[2], mser[2], mber[2], mpsz[2], meop[2], mpgs[2], mer[2];
  int          msnb[2], fill[2], busy_left[2], tgt[2], esec[2];
  logic [31:0] mbuf[2][8];
  logic [31:0] mm  [2][128];
  logic [31:0] exp_rd = '0;

  function automatic logic [31:0] crv(int b);
    return (msnb[b] << 8) | (mpsz[b] << 4) | (mber[b] << 3) | (mser[b] << 2)
         | (mpg[b] << 1) | ((lk[b] != 2) ? 1 : 0);
  endfunction

  function automatic logic [31:0] srv(int b);
    bit bsy = busy_left[b] > 0;
    bit q   = bsy || fill[b] > 0;
    bit wb  = !bsy && fill[b] > 0;
    return (mpgs[b] << 18) | (meop[b] << 16) | (q << 2) | (wb << 1) | bsy;
  endfunction

  function automatic int aidx(logic [20:0] a);
    return (int'(a[19:17]) << 4) | (int'(a[5]) << 3) | int'(a[4:2]);
  endfunction

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 128; i++) mm[b][i] = '1;
  end

  always @(posedge clk) begin : model
    int  b;
    bit  ob[2], oq[2], oo[2], dn[2];
    logic [31:0] d;
    if (rst) begin
      exp_rd = '0;
      for (int k = 0; k < 2; k++) begin
        lk[k] = 0; mpg[k] = 0; mser[k] = 0; mber[k] = 0; mpsz[k] = 0; msnb[k] = 0;
        meop[k] = 0; mpgs[k] = 0; fill[k] = 0; busy_left[k] = 0;
      end
    end else begin
      if (bus_re) begin
        if (bus_reg) begin
          b = int'(bus_addr[8]);
          exp_rd = (bus_addr[7:0] == 8'h0C) ? crv(b) : (bus_addr[7:0] == 8'h10) ? srv(b) : 32'h0;
        end else begin
          exp_rd = mm[int'(bus_addr[20])][aidx(bus_addr)];
        end
      end
      for (int k = 0; k < 2; k++) begin
        ob[k] = busy_left[k] > 0;
        oq[k] = ob[k] || fill[k] > 0;
        oo[k] = lk[k] == 2;
        dn[k] = 0;
        if (busy_left[k] > 0) begin
          busy_left[k]--;
          if (busy_left[k] == 0) begin
            if (mer[k]) for (int i = 0; i < 16; i++) mm[k][esec[k]*16 + i] = '1;
            else        for (int i = 0; i < 8; i++)  mm[k][tgt[k]*8 + i]   = mbuf[k][i];
            meop[k] = 1; dn[k] = 1;
          end
        end
      end
      if (bus_we) begin
        d = bus_wdata;
        if (bus_reg) begin
          b = int'(bus_addr[8]);
          case (bus_addr[7:0])
            8'h04: case (lk[b])
                     0: lk[b] = (d == 32'h45670123) ? 1 : 3;
                     1: lk[b] = (d == 32'hCDEF89AB) ? 2 : 3;
                     default: lk[b] = 3;
                   endcase
            8'h0C: begin
              if (oo[b]) begin
                mpg[b] = d[1]; mser[b] = d[2]; mber[b] = d[3]; mpsz[b] = d[4];
                msnb[b] = int'(d[10:8]);
                if (d[0]) lk[b] = 0;
              end
              if (d[7]) begin
                if (oo[b] && !oq[b] && d[2]) begin
                  busy_left[b] = LAT + 16; mer[b] = 1; esec[b] = int'(d[10:8]);
                end else mpgs[b] = 1;
              end
            end
            8'h10: begin
              if (d[16] && !dn[b]) meop[b] = 0;
              if (d[18]) mpgs[b] = 0;
            end
            default: ;
          endcase
        end else begin
          b = int'(bus_addr[20]);
          if (oo[b] && mpg[b] && !ob[b]) begin
            if (fill[b] == 0) begin
              for (int i = 0; i < 8; i++) mbuf[b][i] = '1;
              tgt[b] = aidx(bus_addr) >> 3;
            end
            mbuf[b][int'(bus_addr[4:2])] = d;
            fill[b]++;
            if (fill[b] == 8) begin
              fill[b] = 0; busy_left[b] = LAT + 8; mer[b] = 0;
            end
          end else mpgs[b] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (bus_rdata !== exp_rd) begin
        bad++;
        $display("FAIL %s model: rdata=%h exp=%h", cur_req, bus_rdata, exp_rd);
      end
    end
  end

  // ---------------- stimulus tasks (called at a falling edge) ----------------
  task automatic wr(input bit r, input logic [20:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_reg = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input bit r, input logic [20:0] a, input logic [31:0] e, input string tag);
    bus_re = 1'b1; bus_reg = r; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    checks++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s: rdata=%h exp=%h", tag, bus_rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic [20:0] key_addr);
    wr(1, key_addr, 32'h45670123);
    wr(1, key_addr, 32'hCDEF89AB);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: rdata=%h exp=%s", bus_rdata, "finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk_en = 1'b1;

    cur_req = "R1";
    rd(1, 21'h00C, 32'h1, "R1 bank0 ctrl after reset");
    rd(1, 21'h010, 32'h0, "R1 bank0 status after reset");
    rd(1, 21'h10C, 32'h1, "R1 bank1 ctrl after reset");

    cur_req = "R9";
    rd(1, 21'h004, 32'h0, "R9 key register reads zero");
    rd(1, 21'h0F0, 32'h0, "R9 unmapped offset reads zero");

    cur_req = "R4";
    wr(1, 21'h00C, 32'h0000_0502);
    rd(1, 21'h00C, 32'h1, "R4 locked ctrl write ignored");

    cur_req = "R8";
    wr(0, 21'h000000, 32'h1234_5678);
    rd(1, 21'h010, 32'h0004_0000, "R8 locked array write flags error");
    wr(1, 21'h010, 32'h0004_0000);
    rd(1, 21'h010, 32'h0, "R8 error cleared by write-one");
    rd(0, 21'h000000, 32'hFFFF_FFFF, "R8 discarded write left array");

    cur_req = "R2";
    unlock(21'h004);
    rd(1, 21'h00C, 32'h0, "R2 bank0 unlocked");
    rd(1, 21'h10C, 32'h1, "R2 bank1 still locked");

    cur_req = "R3";
    wr(1, 21'h104, 32'hCDEF89AB);
    unlock(21'h104);
    rd(1, 21'h10C, 32'h1, "R3 wrong first key locks bank1 for good");

    cur_req = "R4";
    wr(1, 21'h00C, 32'h0000_051E);
    rd(1, 21'h00C, 32'h0000_051E, "R4 ctrl fields readback");
    wr(1, 21'h00C, 32'h0000_0002);
    rd(1, 21'h00C, 32'h0000_0002, "R4 program enable set");

    cur_req = "R5";
    for (int i = 0; i < 3; i++) wr(0, 21'h0A0020 + 21'(4*i), 32'hA500_0000 | i);
    rd(1, 21'h010, 32'h6, "R5 partial buffer sets bits 1 and 2");
    for (int i = 3; i < 8; i++) wr(0, 21'h0A0020 + 21'(4*i), 32'hA500_0000 | i);
    cur_req = "R6";
    idle(LAT + 7);
    rd(1, 21'h010, 32'h5, "R6 busy at last program cycle");
    rd(1, 21'h010, 32'h0001_0000, "R6 end of operation after program");
    cur_req = "R5";
    rd(0, 21'h0A002C, 32'hA500_0003, "R5 lane 3 programmed");
    rd(0, 21'h0A003C, 32'hA500_0007, "R5 lane 7 programmed");
    rd(0, 21'h0A0000, 32'hFFFF_FFFF, "R5 neighbour flash word untouched");

    for (int i = 0; i < 8; i++) wr(0, 21'h0C0000 + 21'(4*i), 32'h5A00_0000 | i);
    idle(LAT + 10);
    rd(0, 21'h0C0008, 32'h5A00_0002, "R5 second flash word programmed");

    cur_req = "R8";
    wr(1, 21'h010, 32'h0001_0000);
    rd(1, 21'h010, 32'h0, "R8 end of operation cleared");

    cur_req = "R7";
    wr(1, 21'h00C, 32'h0000_0584);
    idle(LAT + 15);
    rd(1, 21'h010, 32'h5, "R7 busy at last erase cycle");
    rd(1, 21'h010, 32'h0001_0000, "R6 end of operation after erase");
    rd(0, 21'h0A0020, 32'hFFFF_FFFF, "R7 erased sector reads ones");
    rd(0, 21'h0A0038, 32'hFFFF_FFFF, "R7 erased sector lane 6");
    rd(0, 21'h0C0000, 32'h5A00_0000, "R7 other sector kept");
    wr(1, 21'h010, 32'h0001_0000);

    cur_req = "R8";
    wr(1, 21'h00C, 32'h0000_0080);
    rd(1, 21'h010, 32'h0004_0000, "R8 start without erase bit");
    wr(1, 21'h010, 32'h0004_0000);
    wr(0, 21'h000100, 32'h0BAD_0BAD);
    rd(1, 21'h010, 32'h0004_0000, "R8 array write without program enable");
    wr(1, 21'h010, 32'h0004_0000);
    wr(1, 21'h00C, 32'h0000_0684);
    wr(1, 21'h00C, 32'h0000_0684);
    rd(1, 21'h010, 32'h0004_0005, "R8 start while busy discarded");
    idle(LAT + 20);
    rd(1, 21'h010, 32'h0005_0000, "R8 flags after busy collision");
    wr(1, 21'h010, 32'h0005_0000);
    rd(0, 21'h0C0004, 32'hFFFF_FFFF, "R7 sector 6 erased once");

    cur_req = "R4";
    wr(1, 21'h00C, 32'h0000_0001);
    rd(1, 21'h00C, 32'h1, "R4 relock by writing bit 0");
    wr(1, 21'h00C, 32'h0000_0702);
    rd(1, 21'h00C, 32'h1, "R4 relocked ctrl write ignored");
    cur_req = "R2";
    unlock(21'h004);
    rd(1, 21'h00C, 32'h0, "R2 unlock again after relock");

    cur_req = "R3";
    wr(1, 21'h004, 32'h45670123);
    rd(1, 21'h00C, 32'h1, "R3 key write while unlocked locks");
    unlock(21'h004);
    rd(1, 21'h00C, 32'h1, "R3 bank0 stays locked");

    cur_req = "R1";
    do_reset;
    rd(1, 21'h00C, 32'h1, "R1 bank0 locked after second reset");
    rd(1, 21'h110, 32'h0, "R1 bank1 status after second reset");

    cur_req = "R5";
    unlock(21'h104);
    rd(1, 21'h10C, 32'h0, "R2 bank1 unlocked after reset");
    wr(1, 21'h10C, 32'h0000_0002);
    for (int i = 0; i < 8; i++) wr(0, 21'h140000 + 21'(4*i), 32'hC300_0000 | i);
    idle(LAT + 8);
    rd(1, 21'h110, 32'h0001_0000, "R6 bank1 end of operation");
    rd(0, 21'h140010, 32'hC300_0004, "R5 bank1 lane 4 programmed");
    rd(0, 21'h040010, 32'hFFFF_FFFF, "R5 bank0 same offset untouched");

    cur_req = "R10";
    idle(3);
    checks++;
    if (bus_rdata !== 32'hFFFF_FFFF) begin
      bad++;
      $display("FAIL R10 hold: rdata=%h exp=%h", bus_rdata, 32'hFFFF_FFFF);
    end
    rd(1, 21'h10C, 32'h0000_0002, "R10 next read replaces held value");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule